// File: doc/BRIEF.md
# Static Priority Link Arbiter with Admission Control

This block decides which of several virtual channels may drive a single shared output link. Each channel is tied to one fixed priority level; channel 0 ranks highest and each higher index ranks lower. Channels are bound to the link statically, so this arbiter is the only point where they contend. Its one-hot grant output steers the link multiplexer. A grant is held until the granted channel acknowledges that its flit has crossed the link.

Decisions are made in batches. When the block is idle and no batch is open, it takes a snapshot of the pending requests and freezes it. Requests that arrive after the snapshot wait for the next one. Inside a batch the highest-priority member is granted first. A member whose request has been withdrawn is dropped without a grant. The batch closes only when every member has been served or dropped.

An admission stage sits in front of the priority selector. For every waiting channel it records which higher-priority channels have already overtaken it. Such an overtaker is held out of contention while that waiter is in the batch. As a result, a waiting flit is passed at most once by each higher-priority flit.

Top module: `static_prio_link_arb`

## Requirements
- R1: While reset is high, and in the cycle after it falls, the grant output is all zeros.
- R2: At most one bit of the grant output is set in any cycle.
- R3: With no batch open and no grant active, a clock edge copies the request vector into the batch. A request that rises after that copy is not granted until every member of the batch has been served or dropped.
- R4: Among the batch members that admission allows, the grant goes to the lowest-numbered channel, because channel 0 has the highest priority.
- R5: A grant stays unchanged until the acknowledge bit of the granted channel is high at a clock edge. An acknowledge on any other channel has no effect on the grant.
- R6: Suppose channel H is granted and acknowledged while a lower-priority channel W is requesting. After that, H is not granted ahead of W while both are in a batch, until W itself has been served.
- R7: If a batch member withdraws its request before being granted, it is removed from the batch and never granted from it.
- R8: Latency is fixed. From idle, a request driven before edge k is granted at edge k+1; the grant output is still zero after edge k. An acknowledge seen at an edge clears the grant at that edge. The next grant from the same batch appears at the following edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | NUM_VC | Per-channel flit-pending request, bit 0 is highest priority |
| ack_i | input | NUM_VC | Per-channel acknowledge that the granted flit has been sent |
| gnt_o | output | NUM_VC | One-hot grant that selects the link multiplexer input |

## Verification
Every result has a fixed cycle position. A request driven from idle is captured at the first edge and granted at the second. An acknowledge clears the grant at the edge where it is seen, and the next batch member is granted one edge later. The bench drives inputs after the falling edge and samples the grant one falling edge after each rising edge. This lets it check the zero grant after the capture edge, the zero grant after each acknowledge, and the exact one-hot value after each decision edge. Every nonzero request pattern on four channels is swept this way, and directed sequences cover late arrival, withdrawal, foreign acknowledges and the admission reorder.

// File: rtl/spla_pkg.sv
package spla_pkg;

    // Phase of the arbiter, derived each cycle from its state.
    typedef enum logic [1:0] {
        PH_SAMPLE = 2'd0,  // no grant, batch empty: copy requests
        PH_DECIDE = 2'd1,  // no grant, batch non-empty: pick one
        PH_HOLD   = 2'd2   // grant active, wait for acknowledge
    } arb_phase_t;

    function automatic arb_phase_t phase_of(input logic busy, input logic have_cand);
        if (busy)
            return PH_HOLD;
        else if (have_cand)
            return PH_DECIDE;
        else
            return PH_SAMPLE;
    endfunction

endpackage

// File: rtl/spla_lock.sv
module spla_lock #(
    parameter int NUM_VC = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NUM_VC-1:0] req_i,
    input  logic              busy_i,
    input  logic [NUM_VC-1:0] served_i,
    output logic [NUM_VC-1:0] cand_o
);
    logic [NUM_VC-1:0] locked_q;

    // Live members of the batch: locked and still requesting.
    assign cand_o = locked_q & req_i;

    always_ff @(posedge clk) begin
        if (rst) begin
            locked_q <= '0;
        end else if (!busy_i && (cand_o == '0)) begin
            locked_q <= req_i;
        end else begin
            locked_q <= cand_o & ~served_i;
        end
    end

    // While a batch has live members, it never gains new ones.
    assert_lock_closed_R3: assert property (@(posedge clk) disable iff (rst)
        (cand_o != '0) |=> ((locked_q & ~$past(locked_q)) == '0));

endmodule

// File: rtl/spla_admit.sv
module spla_admit #(
    parameter int NUM_VC = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NUM_VC-1:0] req_i,
    input  logic [NUM_VC-1:0] cand_i,
    input  logic [NUM_VC-1:0] served_i,
    output logic [NUM_VC-1:0] blocked_o
);
    // pass_q[w][h]: higher-priority channel h has overtaken waiter w.
    logic [NUM_VC-1:0] pass_q [NUM_VC];

    genvar h;
    generate
        for (h = 0; h < NUM_VC; h++) begin : g_block
            logic [NUM_VC-1:0] hit;
            always_comb begin
                hit = '0;
                for (int w = 0; w < NUM_VC; w++) begin
                    if (w > h) hit[w] = cand_i[w] & pass_q[w][h];
                end
            end
            assign blocked_o[h] = |hit;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int w = 0; w < NUM_VC; w++) pass_q[w] <= '0;
        end else begin
            for (int w = 0; w < NUM_VC; w++) begin
                if (served_i[w]) begin
                    pass_q[w] <= '0;
                end else if (req_i[w]) begin
                    for (int k = 0; k < NUM_VC; k++) begin
                        if (k < w && served_i[k]) pass_q[w][k] <= 1'b1;
                    end
                end
            end
        end
    end

    // Admission never shuts out a whole non-empty batch.
    assert_admit_live_R6: assert property (@(posedge clk) disable iff (rst)
        (cand_i != '0) |-> ((cand_i & ~blocked_o) != '0));

endmodule

// File: rtl/spla_pick.sv
module spla_pick #(
    parameter int NUM_VC = 4
) (
    input  logic [NUM_VC-1:0] cand_i,
    input  logic [NUM_VC-1:0] blocked_i,
    output logic [NUM_VC-1:0] pick_o
);
    logic [NUM_VC-1:0] elig;
    logic [NUM_VC:0]   seen;

    assign elig    = cand_i & ~blocked_i;
    assign seen[0] = 1'b0;

    genvar i;
    generate
        for (i = 0; i < NUM_VC; i++) begin : g_chain
            assign pick_o[i]  = elig[i] & ~seen[i];
            assign seen[i+1]  = seen[i] | elig[i];
        end
    endgenerate

endmodule

// File: rtl/static_prio_link_arb.sv
module static_prio_link_arb
    import spla_pkg::*;
#(
    parameter int NUM_VC = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NUM_VC-1:0] req_i,
    input  logic [NUM_VC-1:0] ack_i,
    output logic [NUM_VC-1:0] gnt_o
);
    localparam logic [NUM_VC-1:0] ONE_V = NUM_VC'(1);

    logic [NUM_VC-1:0] gnt_q;
    logic [NUM_VC-1:0] served;
    logic [NUM_VC-1:0] cand;
    logic [NUM_VC-1:0] blocked;
    logic [NUM_VC-1:0] pick;
    logic              busy;
    arb_phase_t        phase;

    assign busy   = |gnt_q;
    assign served = gnt_q & ack_i;
    assign phase  = phase_of(busy, |cand);
    assign gnt_o  = gnt_q;

    spla_lock #(.NUM_VC(NUM_VC)) u_lock (
        .clk      (clk),
        .rst      (rst),
        .req_i    (req_i),
        .busy_i   (busy),
        .served_i (served),
        .cand_o   (cand)
    );

    spla_admit #(.NUM_VC(NUM_VC)) u_admit (
        .clk       (clk),
        .rst       (rst),
        .req_i     (req_i),
        .cand_i    (cand),
        .served_i  (served),
        .blocked_o (blocked)
    );

    spla_pick #(.NUM_VC(NUM_VC)) u_pick (
        .cand_i    (cand),
        .blocked_i (blocked),
        .pick_o    (pick)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            gnt_q <= '0;
        end else begin
            case (phase)
                PH_HOLD:   if (served != '0) gnt_q <= '0;
                PH_DECIDE: gnt_q <= pick;
                default:   gnt_q <= '0;
            endcase
        end
    end

    assert_reset_idle_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (gnt_q == '0));

    assert_gnt_onehot_R2: assert property (@(posedge clk) disable iff (rst)
        $onehot0(gnt_q));

    assert_gnt_in_batch_R3: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_DECIDE) |=> ((gnt_q != '0) && ((gnt_q & ~$past(cand)) == '0)));

    assert_gnt_prio_R4: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_DECIDE) |=> (((gnt_q - ONE_V) & $past(cand & ~blocked)) == '0));

    assert_gnt_hold_R5: assert property (@(posedge clk) disable iff (rst)
        (busy && (served == '0)) |=> (gnt_q == $past(gnt_q)));

    assert_gnt_admit_R6: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_DECIDE) |=> ((gnt_q & $past(blocked)) == '0));

    assert_ack_clears_R8: assert property (@(posedge clk) disable iff (rst)
        (served != '0) |=> (gnt_q == '0));

endmodule

// File: tb/sim_static_prio_link_arb.sv
module sim_static_prio_link_arb;
    localparam int NV = 4;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [NV-1:0] req = '0;
    logic [NV-1:0] ack = '0;
    logic [NV-1:0] gnt;

    int  checks   = 0;
    int  failures = 0;
    bit  finished = 1'b0;

    static_prio_link_arb #(.NUM_VC(NV)) u0 (
        .clk   (clk),
        .rst   (rst),
        .req_i (req),
        .ack_i (ack),
        .gnt_o (gnt)
    );

    always #10 clk = ~clk;

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic chk(input string tag, input logic [NV-1:0] act, input logic [NV-1:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%b expected=%b", tag, act, exp);
        end
    endtask

    task automatic report();
        if (!finished) begin
            finished = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    // Grant channel ch is visible now: acknowledge it, retire or keep its request.
    task automatic serve(input int ch, input bit keep_req, input string tag);
        ack = NV'(1) << ch;
        if (!keep_req) req[ch] = 1'b0;
        tick();
        ack = '0;
        chk(tag, gnt, '0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        failures++;
        $display("FAIL R8 watchdog actual=running expected=done");
        report();
    end

    initial begin
        tick();
        tick();
        chk("R1 in reset", gnt, '0);
        rst = 1'b0;
        tick();
        chk("R1 after reset", gnt, '0);

        // Sweep all request patterns from idle: R4 order, R8 timing, R2 one-hot.
        for (int v = 1; v < (1 << NV); v++) begin
            req = NV'(v);
            tick();
            chk("R8 capture edge", gnt, '0);
            tick();
            for (int i = 0; i < NV; i++) begin
                if (v[i]) begin
                    chk("R4 R2 priority order", gnt, NV'(1) << i);
                    serve(i, 1'b0, "R8 ack clears");
                    tick();
                end
            end
            chk("R8 idle after batch", gnt, '0);
        end

        // R3: request rising after the capture waits for the batch to finish.
        req = 4'b0100;
        tick();
        req = 4'b0101;
        tick();
        chk("R3 late arrival excluded", gnt, 4'b0100);
        serve(2, 1'b0, "R8 ack clears");
        tick();
        chk("R3 next capture pending", gnt, '0);
        tick();
        chk("R3 late arrival granted", gnt, 4'b0001);
        serve(0, 1'b0, "R8 ack clears");
        tick();

        // R7: withdrawn batch member is skipped.
        req = 4'b0011;
        tick();
        req = 4'b0010;
        tick();
        chk("R7 withdrawn skipped", gnt, 4'b0010);
        serve(1, 1'b0, "R8 ack clears");
        tick();
        chk("R7 no grant to withdrawn", gnt, '0);
        tick();

        // R6: channel 0 overtakes waiting channel 3, then yields to it once.
        req = 4'b0001;
        tick();
        req = 4'b1001;
        tick();
        chk("R3 first batch only ch0", gnt, 4'b0001);
        serve(0, 1'b1, "R8 ack clears");
        tick();
        chk("R6 capture of both", gnt, '0);
        tick();
        chk("R6 waiter served first", gnt, 4'b1000);

        // R5: hold without acknowledge, then a foreign acknowledge.
        tick();
        chk("R5 hold no ack", gnt, 4'b1000);
        ack = 4'b0010;
        tick();
        ack = '0;
        chk("R5 foreign ack ignored", gnt, 4'b1000);
        tick();
        chk("R5 still held", gnt, 4'b1000);
        serve(3, 1'b0, "R8 ack clears");
        tick();
        chk("R6 overtaker after waiter", gnt, 4'b0001);
        serve(0, 1'b0, "R8 ack clears");
        tick();
        tick();
        chk("R8 idle at end", gnt, '0);

        report();
    end

endmodule